// File: doc/BRIEF.md
# Auto-Reload Down-Counter Timer

This block is a down-counter clocked by a tick enable at the same rate as the time base. Each tick takes one off the count. The tick that moves the count from one to zero produces a single-cycle expiry pulse. A status controller elsewhere uses that pulse to set the decrementer interrupt status and to decide again whether the interrupt output is raised.

At expiry the counter can restart by itself. It does so only when the reload-enable input is high and the separate reload register is nonzero. In that case the count takes the reload value. In every other case the count stays at zero and no further pulses appear until software writes a nonzero count. Keeping a zero reload value out of the counter means a zero reload cannot make the counter fire again and again.

Software uses one write port to write either the count or the reload register, and it can read the current count at any time. A small state machine decides the counter's action each cycle. Its states are:
- `ST_HALTED`: the count is zero.
- `ST_FINAL`: the count is one.
- `ST_RUNNING`: the count is two or more.

Its transitions are:
- **sw-load**: a count write from any state. The new state follows the written value.
- **step**: a tick in `ST_RUNNING`. It goes to `ST_FINAL` when the count was two, and otherwise stays in `ST_RUNNING`.
- **expire-reload**: a tick in `ST_FINAL` with a usable reload value. The new state follows the reload value.
- **expire-stop**: a tick in `ST_FINAL` with no usable reload value. It goes to `ST_HALTED`.
- **idle**: a tick in `ST_HALTED`. It has no effect.

Top module: `dec_reload_timer`

## Requirements
- R1: Reset clears the count to 0 and the reload register to 0, and holds the expiry pulse low.
- R2: With the count above 1 and no count write, a cycle with `tick_en` high lowers the count by exactly 1. A cycle with `tick_en` low leaves the count unchanged.
- R3: A tick taken at count 1 raises `zero_evt` for exactly the one cycle after that clock edge. The updated count is visible in the same cycle.
- R4: At expiry, if `reload_en` is 1 and the reload register is nonzero, the count becomes the reload register value. This includes a reload value of 1, which expires again on the next tick.
- R5: At expiry, if `reload_en` is 0 or the reload register holds 0, the count becomes 0.
- R6: While the count is 0, ticks change nothing and raise no `zero_evt`, until a count write happens.
- R7: A count write (`wr_en`=1, `wr_sel`=0) loads `wr_data` into the count on the next edge. It wins over a tick in the same cycle and never raises `zero_evt` by itself, even when it writes 0.
- R8: A reload write (`wr_en`=1, `wr_sel`=1) stores `wr_data` in the reload register and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-base tick, one decrement per cycle while high |
| reload_en | input | 1 | Auto-reload enable bit from the control register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = count, 1 = reload register |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current count |
| zero_evt | output | 1 | Single-cycle expiry pulse |

## Verification
The bench builds the block with the default `CNT_W` of 32. This lets it load an all-ones count and check that the full-width decrement is correct. The vectors use short counts and reload values of 1 and 5. Those values reach every state, every transition, back-to-back expiries and the zero-reload suppression within a few dozen cycles.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_FINAL   = 2'd1,
        ST_RUNNING = 2'd2
    } dec_state_e;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STEP   = 3'd2,
        OP_RELOAD = 3'd3,
        OP_CLEAR  = 3'd4
    } dec_op_e;

    localparam logic SEL_COUNT  = 1'b0;
    localparam logic SEL_RELOAD = 1'b1;

endpackage

// File: rtl/dec_reload_reg.sv
module dec_reload_reg
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] value_o,
    output logic             nonzero_o,
    output logic             is_one_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr_i) begin
            value_q <= data_i;
        end
    end

    assign value_o   = value_q;
    assign nonzero_o = |value_q;
    assign is_one_o  = (value_q == ONE);

    // R8: a write lands the data on the next edge
    a_r8_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> value_q == $past(data_i));

endmodule

// File: rtl/dec_counter.sv
module dec_counter
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dec_op_e          op_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             is_two_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        unique case (op_i)
            OP_HOLD:   cnt_d = cnt_q;
            OP_LOAD:   cnt_d = wr_data_i;
            OP_STEP:   cnt_d = cnt_q - ONE;
            OP_RELOAD: cnt_d = reload_i;
            OP_CLEAR:  cnt_d = '0;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o  = cnt_q;
    assign is_two_o = (cnt_q == TWO);

    // R2: a step never wraps below zero
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP) |-> cnt_q > ONE);

endmodule

// File: rtl/dec_fsm.sv
module dec_fsm
    import dec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    cnt_wr_i,
    input  logic    wr_zero_i,
    input  logic    wr_one_i,
    input  logic    cnt_two_i,
    input  logic    reload_ok_i,
    input  logic    reload_one_i,
    output dec_op_e op_o,
    output logic    evt_o
);

    dec_state_e state_q;
    dec_state_e state_d;
    logic       evt_q;

    // next state
    always_comb begin
        state_d = state_q;
        if (cnt_wr_i) begin
            // sw-load
            state_d = wr_zero_i ? ST_HALTED : (wr_one_i ? ST_FINAL : ST_RUNNING);
        end else if (tick_i) begin
            unique case (state_q)
                ST_HALTED:  state_d = ST_HALTED;                       // idle
                ST_RUNNING: state_d = cnt_two_i ? ST_FINAL : ST_RUNNING; // step
                ST_FINAL: begin
                    if (reload_ok_i) begin                              // expire-reload
                        state_d = reload_one_i ? ST_FINAL : ST_RUNNING;
                    end else begin                                      // expire-stop
                        state_d = ST_HALTED;
                    end
                end
                default:    state_d = ST_HALTED;
            endcase
        end
    end

    // state register and expiry pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= tick_i && !cnt_wr_i && (state_q == ST_FINAL);
        end
    end

    // outputs
    always_comb begin
        op_o = OP_HOLD;
        if (cnt_wr_i) begin
            op_o = OP_LOAD;
        end else if (tick_i) begin
            unique case (state_q)
                ST_HALTED:  op_o = OP_HOLD;
                ST_RUNNING: op_o = OP_STEP;
                ST_FINAL:   op_o = reload_ok_i ? OP_RELOAD : OP_CLEAR;
                default:    op_o = OP_HOLD;
            endcase
        end
    end

    assign evt_o = evt_q;

    // R6: from halted, only a write leaves the state
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED && !cnt_wr_i) |=> state_q == ST_HALTED && !evt_q);

endmodule

// File: rtl/dec_reload_timer.sv
module dec_reload_timer
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reload_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             cnt_wr;
    logic             rld_wr;
    logic [CNT_W-1:0] rld_val;
    logic             rld_nz;
    logic             rld_one;
    logic             cnt_two;
    dec_op_e          op;

    assign cnt_wr = wr_en && (wr_sel == SEL_COUNT);
    assign rld_wr = wr_en && (wr_sel == SEL_RELOAD);

    dec_reload_reg #(.CNT_W(CNT_W)) u_reload (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (rld_wr),
        .data_i    (wr_data),
        .value_o   (rld_val),
        .nonzero_o (rld_nz),
        .is_one_o  (rld_one)
    );

    dec_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_en),
        .cnt_wr_i     (cnt_wr),
        .wr_zero_i    (wr_data == '0),
        .wr_one_i     (wr_data == ONE),
        .cnt_two_i    (cnt_two),
        .reload_ok_i  (reload_en && rld_nz),
        .reload_one_i (rld_one),
        .op_o         (op),
        .evt_o        (zero_evt)
    );

    dec_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .wr_data_i (wr_data),
        .reload_i  (rld_val),
        .count_o   (count),
        .is_two_o  (cnt_two)
    );

    // R3: a pulse follows only a tick taken at count one
    a_r3_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> ($past(count) == ONE && $past(tick_en) && !$past(cnt_wr)));

    // R4: reload value lands on expiry
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && $past(reload_en) && $past(rld_val) != '0) |-> count == $past(rld_val));

    // R5: no usable reload leaves zero
    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && (!$past(reload_en) || $past(rld_val) == '0)) |-> count == '0);

    // R7: a count write wins
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wr_data) && !zero_evt));

    // R2: decrement by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr && count > ONE) |=> count == $past(count) - ONE);

endmodule

// File: tb/test_dec_reload_timer.sv
module test_dec_reload_timer;

    localparam int CNT_W   = 32;
    localparam time CLK_PER = 10ns;
    localparam int NVEC    = 22;
    localparam int WDOG    = 5000;

    typedef struct packed {
        logic             wr;
        logic             sel;
        logic [CNT_W-1:0] data;
        logic             tick;
        logic             ren;
        logic [CNT_W-1:0] exp_cnt;
        logic             exp_evt;
        logic [3:0]       req;
    } vec_t;

    // sel: 0 = count, 1 = reload register
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 32'd3,          1'b1, 1'b0, 32'd3,          1'b0, 4'd7}, // R7 write beats tick
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b0, 32'd2,          1'b0, 4'd2}, // R2
        '{1'b0, 1'b0, 32'd0,          1'b0, 1'b0, 32'd2,          1'b0, 4'd2}, // R2 hold
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b0, 32'd1,          1'b0, 4'd2},
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b0, 32'd0,          1'b1, 4'd3}, // R3 R5
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b0, 32'd0,          1'b0, 4'd6}, // R6
        '{1'b1, 1'b1, 32'd5,          1'b1, 1'b1, 32'd0,          1'b0, 4'd8}, // R8
        '{1'b1, 1'b0, 32'd2,          1'b0, 1'b1, 32'd2,          1'b0, 4'd7},
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd1,          1'b0, 4'd2},
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd5,          1'b1, 4'd4}, // R4
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd4,          1'b0, 4'd2},
        '{1'b1, 1'b1, 32'd0,          1'b0, 1'b1, 32'd4,          1'b0, 4'd8},
        '{1'b1, 1'b0, 32'd1,          1'b0, 1'b1, 32'd1,          1'b0, 4'd7},
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd0,          1'b1, 4'd5}, // R5 zero reload
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd0,          1'b0, 4'd6},
        '{1'b1, 1'b0, 32'd0,          1'b1, 1'b1, 32'd0,          1'b0, 4'd7}, // R7 write of 0
        '{1'b1, 1'b1, 32'd1,          1'b0, 1'b1, 32'd0,          1'b0, 4'd8},
        '{1'b1, 1'b0, 32'd1,          1'b0, 1'b1, 32'd1,          1'b0, 4'd7},
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd1,          1'b1, 4'd4}, // R4 reload 1
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd1,          1'b1, 4'd4},
        '{1'b1, 1'b0, 32'hFFFF_FFFF,  1'b0, 1'b0, 32'hFFFF_FFFF,  1'b0, 4'd7},
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b0, 32'hFFFF_FFFE,  1'b0, 4'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             reload_en = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count;
    logic             zero_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    dec_reload_timer #(.CNT_W(CNT_W)) i_dec_reload_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reload_en (reload_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .count     (count),
        .zero_evt  (zero_evt)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] ec, input logic ee);
        checks++;
        if (count !== ec || zero_evt !== ee) begin
            fails++;
            $display("FAIL %s: count=%0h evt=%0b expected count=%0h evt=%0b",
                     req, count, zero_evt, ec, ee);
        end
    endtask

    // drive on falling edge, sample just after next rising edge
    task automatic step(input logic w, input logic s, input logic [CNT_W-1:0] d,
                        input logic t, input logic r);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d; tick_en = t; reload_en = r;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    initial begin
        // R1 reset state
        #(CLK_PER*2);
        check("R1", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0, 1'b1, 1'b1);
        check("R1 tick after reset", '0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].wr, VEC[i].sel, VEC[i].data, VEC[i].tick, VEC[i].ren);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].exp_cnt, VEC[i].exp_evt);
        end

        // R1: mid-run reset clears count and reload register
        step(1'b1, 1'b1, 32'd9, 1'b0, 1'b1);
        step(1'b1, 1'b0, 32'd7, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 32'd1, 1'b0, 1'b1);
        step(1'b0, 1'b0, '0, 1'b1, 1'b1);
        check("R1 reload cleared", '0, 1'b1);

        // R3: pulse lasts one cycle only
        step(1'b0, 1'b0, '0, 1'b0, 1'b1);
        check("R3 pulse width", '0, 1'b0);

        // R7: write 1 then tick expires
        step(1'b1, 1'b0, 32'd1, 1'b1, 1'b0);
        check("R7 write of 1", 32'd1, 1'b0);
        step(1'b0, 1'b0, '0, 1'b1, 1'b0);
        check("R3 expiry after write", '0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected end before %0d cycles", WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule